// File: doc/BRIEF.md
# ZVS Full-Bridge Gate Timing Generator

This block produces the gate timing for a fixed-frequency, zero-voltage-switching full bridge. It generates four bridge gate signals, an upper and a lower switch for each of two legs, and one synchronous-rectifier gate per leg. All timing is counted in cycles of the system clock. An internal phase counter divides time into phases of a programmable length. Two phases make one switching period, so the switching frequency is half the phase rate.

During each phase, one upper switch is held on for the whole phase, which gives each upper output a 50% duty cycle. The lower switch of the opposite leg turns on after a programmable resonant delay, counted from the moment its own upper switch turned off. That lower switch turns off when either of two things happens: an external comparator raises the terminate input, or the programmable dead-time window at the end of the phase is reached. Each rectifier gate follows its upper output but drops one dead time earlier. The period, dead time and resonant delay are taken from input ports. They are captured only while the block is disabled or at a phase boundary.

Top module: `zvs_bridge_timer`

## Requirements
- R1: Each phase lasts exactly PERIOD cycles. After enable, the first phase has even parity. `upper_o[0]` is high for every cycle of even phases and `upper_o[1]` is high for every cycle of odd phases.
- R2: While running and enabled, `upper_o[0]` and `upper_o[1]` are always complementary.
- R3: Let c be the cycle index within a phase, starting at 0. The lower output of leg k is high only in the phases where `upper_o[k]` is low. It first goes high at c = RESDLY, which is RESDLY cycles after its upper output fell.
- R4: If terminate is sampled high in a cycle where the lower output is high, the lower output is low from the next cycle until the end of that phase. The following phase is not affected.
- R5: If terminate is sampled high before the resonant delay has elapsed, the lower output stays low for the whole of that phase.
- R6: With no terminate, the lower output is high for c in the range RESDLY to PERIOD−DEAD−1, inclusive. It is low during the last DEAD cycles of the phase, so it is off at least DEAD cycles before the upper output of the same leg turns on.
- R7: `sync_o[k]` is high exactly while `upper_o[k]` is high and c < PERIOD−DEAD. It therefore falls DEAD cycles before `upper_o[k]` falls.
- R8: A change of `period_i`, `dead_i` or `resdly_i` in the middle of a phase has no effect on that phase. It takes effect from the next phase.
- R9: When `en_i` is low, all six outputs are low in that same cycle. After `en_i` returns high, the block restarts at an even phase with c = 0, in the cycle after the first clock edge that samples `en_i` high.
- R10: While `rst_ni` is low, all outputs are low, whatever the value of `en_i`.
- R11: The upper and lower outputs of the same leg are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low forces all outputs low |
| term_i | input | 1 | Trailing-edge terminate from the current comparator |
| period_i | input | CNT_W | Phase length in cycles (PERIOD) |
| dead_i | input | CNT_W | Dead-time length in cycles (DEAD) |
| resdly_i | input | CNT_W | Resonant delay in cycles (RESDLY) |
| upper_o | output | 2 | Upper switch gates, index = leg |
| lower_o | output | 2 | Lower switch gates, index = leg |
| sync_o | output | 2 | Synchronous-rectifier gates, index = leg |

## Verification
The bench drives nine combinations of period, dead time and resonant delay, each over a full even and odd phase:
- The runs without terminate measure the free-running window and show whether the resonant delay and dead time are counted from the correct ends of the phase.
- Terminate placed inside the lower pulse shows that truncation takes effect on the next cycle.
- Terminate placed one cycle before the resonant delay expires, and exactly when it expires, separates the case that suppresses the pulse from the case that leaves a single-cycle pulse.
- The extreme settings, zero resonant delay and a dead time of one cycle less than the period, probe the edges of the compare windows.

Directed runs then change the configuration in the middle of a phase and drop the enable in the middle of a phase, to separate shadowed timing from live timing and to confirm a clean restart.

// File: rtl/zvs_pkg.sv
package zvs_pkg;
  localparam int unsigned NUM_LEGS = 2;
  typedef enum logic {PH_EVEN = 1'b0, PH_ODD = 1'b1} phase_e;
endpackage

// File: rtl/zvs_phase_clk.sv
module zvs_phase_clk
  import zvs_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned DEF_PER  = 20,
  parameter int unsigned DEF_DEAD = 2,
  parameter int unsigned DEF_RD   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] dead_i,
  input  logic [CNT_W-1:0] resdly_i,
  output logic             run_o,
  output logic             wrap_o,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] dead_o,
  output logic [CNT_W-1:0] rd_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q, per_q, dead_q, rd_q, last_cnt;
  phase_e           ph_q;
  logic             wrap;

  // phases shorter than two cycles are stretched to two
  always_comb begin
    last_cnt = (per_q < TWO) ? ONE : (per_q - ONE);
    wrap     = run_q && (cnt_q == last_cnt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      ph_q   <= PH_EVEN;
      per_q  <= CNT_W'(DEF_PER);
      dead_q <= CNT_W'(DEF_DEAD);
      rd_q   <= CNT_W'(DEF_RD);
    end else begin
      run_q <= en_i;
      if (!en_i || !run_q) begin
        cnt_q  <= '0;
        ph_q   <= PH_EVEN;
        per_q  <= period_i;
        dead_q <= dead_i;
        rd_q   <= resdly_i;
      end else if (wrap) begin
        cnt_q  <= '0;
        ph_q   <= (ph_q == PH_EVEN) ? PH_ODD : PH_EVEN;
        per_q  <= period_i;
        dead_q <= dead_i;
        rd_q   <= resdly_i;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end

  assign run_o   = run_q;
  assign wrap_o  = wrap;
  assign phase_o = ph_q;
  assign cnt_o   = cnt_q;
  assign per_o   = per_q;
  assign dead_o  = dead_q;
  assign rd_o    = rd_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && en_i && !wrap) |=> ($stable(per_q) && $stable(dead_q) && $stable(rd_q))); // R8
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q <= last_cnt)); // R1
  AST_PHASE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && en_i) |=> (ph_q != $past(ph_q))); // R1
endmodule

// File: rtl/zvs_leg.sv
module zvs_leg
  import zvs_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned LEG   = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             term_i,
  input  logic             run_i,
  input  logic             wrap_i,
  input  phase_e           phase_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] dead_i,
  input  logic [CNT_W-1:0] rd_i,
  output logic             upper_o,
  output logic             lower_o,
  output logic             sync_o
);
  localparam phase_e OWN_PH = (LEG == 0) ? PH_EVEN : PH_ODD;
  localparam int unsigned SUM_W = CNT_W + 1;

  logic term_q;
  logic active, before_dead;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                term_q <= 1'b0;
    else if (!run_i || wrap_i)  term_q <= 1'b0;
    else if (term_i)            term_q <= 1'b1;
  end

  always_comb begin
    active      = run_i && en_i;
    before_dead = (SUM_W'(cnt_i) + SUM_W'(dead_i)) < SUM_W'(per_i);
    upper_o     = active && (phase_i == OWN_PH);
    sync_o      = upper_o && before_dead;
    lower_o     = active && (phase_i != OWN_PH) && (cnt_i >= rd_i)
                  && before_dead && !term_q;
  end

  AST_LEG_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(upper_o && lower_o)); // R11
  AST_SYNC_IN_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> upper_o); // R7
  AST_TERM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && term_i && !wrap_i) |=> !lower_o); // R4
  AST_DEAD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(upper_o) && (dead_i != '0)) |-> !$past(lower_o)); // R6
endmodule

// File: rtl/zvs_bridge_timer.sv
module zvs_bridge_timer
  import zvs_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                term_i,
  input  logic [CNT_W-1:0]    period_i,
  input  logic [CNT_W-1:0]    dead_i,
  input  logic [CNT_W-1:0]    resdly_i,
  output logic [NUM_LEGS-1:0] upper_o,
  output logic [NUM_LEGS-1:0] lower_o,
  output logic [NUM_LEGS-1:0] sync_o
);
  logic             run, wrap;
  phase_e           phase;
  logic [CNT_W-1:0] cnt, per, dead, rd;

  zvs_phase_clk #(.CNT_W(CNT_W)) u_clk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .period_i (period_i),
    .dead_i   (dead_i),
    .resdly_i (resdly_i),
    .run_o    (run),
    .wrap_o   (wrap),
    .phase_o  (phase),
    .cnt_o    (cnt),
    .per_o    (per),
    .dead_o   (dead),
    .rd_o     (rd)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    zvs_leg #(.CNT_W(CNT_W), .LEG(g)) u_leg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_i),
      .term_i  (term_i),
      .run_i   (run),
      .wrap_i  (wrap),
      .phase_i (phase),
      .cnt_i   (cnt),
      .per_i   (per),
      .dead_i  (dead),
      .rd_i    (rd),
      .upper_o (upper_o[g]),
      .lower_o (lower_o[g]),
      .sync_o  (sync_o[g])
    );
  end

  AST_UPPER_COMPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && en_i) |-> (upper_o[0] != upper_o[1])); // R2
  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> ((upper_o | lower_o | sync_o) == '0)); // R9
endmodule

// File: tb/sim_zvs_bridge_timer.sv
module sim_zvs_bridge_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int NV = 9;
  // period, dead, resdly, term cycle (-1 none), exp lower start (-1 none), exp lower len, exp sync len
  localparam int VEC [NV][7] = '{
    '{20,  3,  4, -1,  4, 13, 17},
    '{40,  5, 10, -1, 10, 25, 35},
    '{20,  3,  4,  8,  4,  5, 17},
    '{20,  3,  4,  2, -1,  0, 17},
    '{16,  1,  1, -1,  1, 14, 15},
    '{12,  2,  0, -1,  0, 10, 10},
    '{30, 10,  5,  4, -1,  0, 20},
    '{30, 10,  5,  5,  5,  1, 20},
    '{10,  9,  0, -1,  0,  1,  1}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0;
  logic term = 1'b0;
  logic [CNT_W-1:0] per_r = 8'd20, dead_r = 8'd3, rd_r = 8'd4;
  logic [1:0] upper, lower, sync;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zvs_bridge_timer #(.CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .term_i(term),
    .period_i(per_r), .dead_i(dead_r), .resdly_i(rd_r),
    .upper_o(upper), .lower_o(lower), .sync_o(sync)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic start_run(input int p, input int d, input int r);
    @(posedge clk); #1;
    en = 1'b0; per_r = CNT_W'(p); dead_r = CNT_W'(d); rd_r = CNT_W'(r);
    @(posedge clk); #1;
    en = 1'b1;
  endtask

  // one phase; ph = expected parity; optional config change at cycle chg_at
  task automatic run_phase(input int p, input int t, input int ph, input int est,
                           input int elen, input int esync, input int chg_at,
                           input int np, input int nd, input int nr, output int up_cnt);
    int first = -1, len = 0, sc = 0, cmp = 0, ovl = 0;
    up_cnt = 0;
    for (int c = 0; c < p; c++) begin
      @(posedge clk); #1;
      term = (c == t);
      if (c == chg_at) begin
        per_r = CNT_W'(np); dead_r = CNT_W'(nd); rd_r = CNT_W'(nr);
      end
      @(negedge clk);
      if (upper[ph]) up_cnt++;
      if (upper[1-ph] || upper[0] == upper[1]) cmp++;
      if (sync[ph]) sc++;
      if (sync[1-ph] || lower[ph]) ovl++;
      if ((upper[0] && lower[0]) || (upper[1] && lower[1])) ovl++;
      if (lower[1-ph]) begin
        if (first < 0) first = c;
        len++;
      end
    end
    term = 1'b0;
    chk(up_cnt == p, "R1 upper phase length", up_cnt, p);
    chk(cmp == 0, "R2 upper complement", cmp, 0);
    chk(sc == esync, "R7 sync length", sc, esync);
    chk(first == est, (elen == 0) ? "R5 lower suppressed" : "R3 lower start", first, est);
    chk(len == elen, (t >= 0) ? "R4 lower truncated" : "R6 lower window", len, elen);
    chk(ovl == 0, "R11 leg overlap / wrong leg", ovl, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int uc;
    // R10: reset holds outputs low even with enable high
    en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({upper, lower, sync} == '0, "R10 outputs in reset", {upper, lower, sync}, 0);
    en = 1'b0;
    @(posedge clk); #1;
    rst_ni = 1'b1;
    @(negedge clk);
    chk({upper, lower, sync} == '0, "R10 outputs after reset", {upper, lower, sync}, 0);

    // table walk: even phase then odd phase for each setting
    for (int i = 0; i < NV; i++) begin
      start_run(VEC[i][0], VEC[i][1], VEC[i][2]);
      for (int ph = 0; ph < 2; ph++)
        run_phase(VEC[i][0], VEC[i][3], ph, VEC[i][4], VEC[i][5], VEC[i][6],
                  -1, 0, 0, 0, uc);
    end

    // R8: mid-phase config change applies from next phase only
    start_run(20, 3, 4);
    run_phase(20, -1, 0, 4, 13, 17, 5, 10, 2, 3, uc);
    chk(uc == 20, "R8 old period kept", uc, 20);
    run_phase(10, -1, 1, 3, 5, 8, -1, 0, 0, 0, uc);
    chk(uc == 10, "R8 new period applied", uc, 10);

    // R9: enable drop mid-phase, then restart at even phase
    start_run(20, 3, 4);
    for (int c = 0; c < 6; c++) @(posedge clk);
    @(negedge clk);
    chk(upper[0] == 1'b1, "R9 running before drop", upper[0], 1);
    @(posedge clk); #1;
    en = 1'b0;
    @(negedge clk);
    chk({upper, lower, sync} == '0, "R9 outputs low when disabled", {upper, lower, sync}, 0);
    @(posedge clk); #1;
    en = 1'b1;
    @(negedge clk);
    chk({upper, lower, sync} == '0, "R9 idle before restart edge", {upper, lower, sync}, 0);
    run_phase(20, -1, 0, 4, 13, 17, -1, 0, 0, 0, uc);
    chk(uc == 20, "R9 restart at even phase", uc, 20);

    summary();
  end
endmodule